// File: doc/BRIEF.md
# Sequential Significand Divider

This block divides one normalized floating-point significand by another and delivers the normalized quotient significand, the adjusted result exponent and a sticky bit. Each operand significand is an unsigned fixed-point value in [1.0, 2.0), with its leading one at the top bit. Each exponent is a signed two's-complement value. Signs, special operands, rounding and packing belong to the surrounding floating-point unit. The divider expects both operands to be finite, nonzero and normalized.

The quotient is built one bit per clock, most significant bit first, by restoring division. The first trial step also normalizes the result. It subtracts the divisor from the dividend. When that difference is negative, the result exponent is lowered by one and the doubled dividend is used instead. The leading quotient bit is therefore always one. The quotient carries two extra low-order positions, for guard and round. The sticky bit reports whether any remainder is left after the last quotient bit.

The operands travel with a plain start/busy/done handshake. A start is taken only while the divider is idle, and the operands are captured on that edge. The divider offers no back-pressure beyond this: a start raised while busy is dropped, and the requester must wait for busy to fall. The results are registered. They stay unchanged from the done pulse until the next accepted start.

Top module: `mant_div_seq`

## Requirements
- R1: While idle and out of reset, start=1 at a rising edge captures a_sig, b_sig, a_exp and b_exp, and busy is high after that edge. Later changes on the operand inputs do not alter the result.
- R2: A start raised while busy is high is ignored: the running division finishes at its normal time with the results of the operands captured at the accepted start.
- R3: done is high for exactly one cycle, starting at the QUOT_W-th rising edge after the edge that accepted start (QUOT_W = MANT_W + 2). busy stays high until that same edge and is low while done is high.
- R4: q_exp equals a_exp − b_exp when a_sig ≥ b_sig, and a_exp − b_exp − 1 otherwise. It is computed as a signed value of EXP_W + 1 bits.
- R5: The top bit of q_sig (bit QUOT_W−1) is 1 in every result.
- R6: q_sig equals floor(a_sig · 2^(QUOT_W−1) / b_sig) when a_sig ≥ b_sig, and floor(a_sig · 2^QUOT_W / b_sig) otherwise. Both significands are read as unsigned integers. The two lowest bits of q_sig are the guard and round positions.
- R7: sticky is 1 exactly when the division in R6 leaves a nonzero remainder.
- R8: After done, q_sig, q_exp and sticky hold their values until the next accepted start.
- R9: After reset, busy, done, sticky, q_sig and q_exp are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a division; taken only while idle |
| a_sig | input | MANT_W | Dividend significand in [1.0, 2.0), leading one at the top bit |
| b_sig | input | MANT_W | Divisor significand in [1.0, 2.0), leading one at the top bit |
| a_exp | input | EXP_W | Dividend exponent, signed |
| b_exp | input | EXP_W | Divisor exponent, signed |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: the results are valid |
| q_sig | output | MANT_W+2 | Normalized quotient significand with guard and round bits |
| q_exp | output | EXP_W+1 | Result exponent, signed |
| sticky | output | 1 | Nonzero remainder after the last quotient bit |

## Verification
The bench targets the normalization boundary from both sides: equal significands, a dividend one unit above the divisor and one unit below it. A design that tested the first difference for strict positivity, or that forgot the exponent decrement, would give a wrong exponent there, a quotient without its leading one, or a quotient off by a factor of two. Exact quotients, such as a maximal dividend over 1.0 or equal operands, must give sticky = 0. Quotients that do not terminate must give sticky = 1, which exposes a sticky taken from a quotient bit rather than from the remainder. Extreme exponent pairs reach −256 and +255 and catch an exponent path that is too narrow or unsigned. A second start raised mid-division, with different operands on the inputs, catches a controller that restarts or recaptures.

// File: rtl/mdiv_pkg.sv
package mdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_RUN   = 2'd2
  } mdiv_state_e;
endpackage

// File: rtl/mdiv_trial.sv
// Trial subtraction: the sign of (minuend - divisor) decides the quotient bit.
module mdiv_trial #(
  parameter int RW = 25,
  parameter int YW = 24
) (
  input  logic [RW-1:0] minuend,
  input  logic [YW-1:0] divisor,
  output logic [RW-1:0] diff,
  output logic          nonneg
);
  logic [RW:0] full;

  assign full   = {1'b0, minuend} - {{(RW + 1 - YW){1'b0}}, divisor};
  assign diff   = full[RW-1:0];
  assign nonneg = ~full[RW];
endmodule

// File: rtl/mdiv_expo.sv
// Result exponent, one bit wider than the operands, with normalization adjust.
module mdiv_expo #(
  parameter int EXP_W = 8
) (
  input  logic signed [EXP_W-1:0] ea,
  input  logic signed [EXP_W-1:0] eb,
  input  logic                    lshift,
  output logic signed [EXP_W:0]   eq
);
  logic signed [EXP_W:0] ea_x;
  logic signed [EXP_W:0] eb_x;
  logic signed [EXP_W:0] adj;

  assign ea_x = EXP_W'(0) + ea;
  assign eb_x = EXP_W'(0) + eb;
  assign adj  = $signed({{EXP_W{1'b0}}, lshift});
  assign eq   = ea_x - eb_x - adj;
endmodule

// File: rtl/mdiv_ctrl.sv
// Sequencer: load edge, first (normalizing) step, then QUOT_W-1 plain steps.
module mdiv_ctrl
  import mdiv_pkg::*;
#(
  parameter int QUOT_W = 26
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic first,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(QUOT_W);

  mdiv_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;

  assign load  = (state_q == ST_IDLE) && start;
  assign first = (state_q == ST_FIRST);
  assign step  = (state_q == ST_RUN);
  assign last  = step && (cnt_q == '0);
  assign busy  = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done    <= 1'b0;
    end else begin
      done <= last;
      unique case (state_q)
        ST_IDLE:  if (start) state_q <= ST_FIRST;
        ST_FIRST: begin
          state_q <= ST_RUN;
          cnt_q   <= CNT_W'(QUOT_W - 2);
        end
        ST_RUN: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last) |=> busy && !first); // R2
endmodule

// File: rtl/mant_div_seq.sv
module mant_div_seq #(
  parameter int MANT_W = 24,
  parameter int EXP_W  = 8,
  parameter int QUOT_W = MANT_W + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [MANT_W-1:0]       a_sig,
  input  logic [MANT_W-1:0]       b_sig,
  input  logic signed [EXP_W-1:0] a_exp,
  input  logic signed [EXP_W-1:0] b_exp,
  output logic                    busy,
  output logic                    done,
  output logic [QUOT_W-1:0]       q_sig,
  output logic signed [EXP_W:0]   q_exp,
  output logic                    sticky
);
  // Remainder holds values below 4.0 after a shift: one bit above the significand.
  localparam int RW = MANT_W + 1;

  logic load, first, step, last;

  logic [RW-1:0]           rem_q, rem_shl, rem_nxt;
  logic [MANT_W-1:0]       div_q;
  logic signed [EXP_W-1:0] ea_q, eb_q;
  logic signed [EXP_W:0]   exp_calc;
  logic [RW-1:0]           d_dir, d_shf;
  logic                    nn_dir, nn_shf;

  mdiv_ctrl #(.QUOT_W(QUOT_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .first (first),
    .step  (step),
    .last  (last),
    .busy  (busy),
    .done  (done)
  );

  assign rem_shl = {rem_q[RW-2:0], 1'b0};

  // Unshifted trial: X - Y, only meaningful in the first step.
  mdiv_trial #(.RW(RW), .YW(MANT_W)) u_trial_dir (
    .minuend (rem_q),
    .divisor (div_q),
    .diff    (d_dir),
    .nonneg  (nn_dir)
  );

  // Shifted trial: 2R - Y, every later step and the X < Y first step.
  mdiv_trial #(.RW(RW), .YW(MANT_W)) u_trial_shf (
    .minuend (rem_shl),
    .divisor (div_q),
    .diff    (d_shf),
    .nonneg  (nn_shf)
  );

  mdiv_expo #(.EXP_W(EXP_W)) u_expo (
    .ea     (ea_q),
    .eb     (eb_q),
    .lshift (~nn_dir),
    .eq     (exp_calc)
  );

  always_comb begin
    rem_nxt = rem_q;
    if (first)     rem_nxt = nn_dir ? d_dir : d_shf;
    else if (step) rem_nxt = nn_shf ? d_shf : rem_shl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      div_q  <= '0;
      ea_q   <= '0;
      eb_q   <= '0;
      q_sig  <= '0;
      q_exp  <= '0;
      sticky <= 1'b0;
    end else begin
      if (load) begin
        rem_q <= {1'b0, a_sig};
        div_q <= b_sig;
        ea_q  <= a_exp;
        eb_q  <= b_exp;
      end else begin
        rem_q <= rem_nxt;
      end
      if (first) begin
        q_sig <= QUOT_W'(1);
        q_exp <= exp_calc;
      end else if (step) begin
        q_sig <= {q_sig[QUOT_W-2:0], nn_shf};
      end
      if (last) sticky <= |rem_nxt;
    end
  end

  AST_SIG_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (a_sig[MANT_W-1] && b_sig[MANT_W-1])); // R1
  AST_FIRST_SHIFTED_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (first && !nn_dir) |-> nn_shf); // R4
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (rem_q < {1'b0, div_q})); // R6
  AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> q_sig[QUOT_W-1]); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(q_sig) && $stable(q_exp) && $stable(sticky))); // R8
endmodule

// File: tb/mant_div_seq_bench.sv
`timescale 1ns/1ps
module mant_div_seq_bench;
  localparam int MW = 24;
  localparam int EW = 8;
  localparam int QW = MW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [MW-1:0] a_sig = '0, b_sig = '0;
  logic signed [EW-1:0] a_exp = '0, b_exp = '0;
  logic busy, done, sticky;
  logic [QW-1:0] q_sig;
  logic signed [EW:0] q_exp;

  int n_total = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  mant_div_seq #(.MANT_W(MW), .EXP_W(EW)) u_mant_div_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_sig(a_sig), .b_sig(b_sig), .a_exp(a_exp), .b_exp(b_exp),
    .busy(busy), .done(done), .q_sig(q_sig), .q_exp(q_exp), .sticky(sticky)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One division; if intrude, a second start with other operands is raised mid-run.
  task automatic run_div(input logic [MW-1:0] a, input logic [MW-1:0] b,
                         input int ea, input int eb, input bit intrude);
    longint unsigned num, qexp, rexp;
    int eexp, n;
    bit busy_ok;
    num  = (a >= b) ? (longint'(a) << (QW - 1)) : (longint'(a) << QW);
    qexp = num / b;
    rexp = num % b;
    eexp = ea - eb - ((a < b) ? 1 : 0);
    @(negedge clk);
    a_sig = a; b_sig = b; a_exp = EW'(ea); b_exp = EW'(eb); start = 1'b1;
    @(posedge clk); #1;
    chk(busy == 1'b1, "R1", "busy after start", longint'(busy), 1);
    n = 0;
    busy_ok = 1'b1;
    while (n < QW + 4) begin
      @(negedge clk);
      start = intrude && (n == 3);
      a_sig = 24'hC3A5F1; b_sig = 24'h812345; a_exp = 8'sd99; b_exp = -8'sd77;
      @(posedge clk); #1;
      n++;
      if (done) break;
      if (!busy) busy_ok = 1'b0;
    end
    start = 1'b0;
    chk(n == QW, intrude ? "R2" : "R3", "latency", longint'(n), QW);
    chk(busy_ok, "R3", "busy held during run", longint'(busy_ok), 1);
    chk(busy == 1'b0, "R3", "busy low at done", longint'(busy), 0);
    chk(q_sig == qexp, intrude ? "R2" : "R6", "quotient", longint'(q_sig), longint'(qexp));
    chk(q_sig[QW-1] == 1'b1, "R5", "leading bit", longint'(q_sig[QW-1]), 1);
    chk(int'(q_exp) == eexp, "R4", "exponent", longint'(q_exp), longint'(eexp));
    chk(sticky == (rexp != 0), "R7", "sticky", longint'(sticky), longint'(rexp != 0));
    @(posedge clk); #1;
    chk(done == 1'b0, "R3", "done single cycle", longint'(done), 0);
  endtask

  task automatic test_reset();
    chk(busy == 1'b0 && done == 1'b0, "R9", "busy/done after reset", longint'({busy, done}), 0);
    chk(q_sig == '0 && sticky == 1'b0, "R9", "q_sig/sticky after reset", longint'(q_sig), 0);
    chk(q_exp == '0, "R9", "q_exp after reset", longint'(q_exp), 0);
  endtask

  task automatic test_hold();
    logic [QW-1:0] qs;
    logic signed [EW:0] qe;
    logic st;
    qs = q_sig; qe = q_exp; st = sticky;
    repeat (6) begin
      @(negedge clk);
      a_sig = ~a_sig; b_exp = b_exp + 8'sd3;
    end
    @(posedge clk); #1;
    chk(q_sig == qs && q_exp == qe && sticky == st, "R8", "results held after done",
        longint'(q_sig), longint'(qs));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    test_reset();
    run_div(24'hC00000, 24'hC00000, 5, 3, 1'b0);       // equal significands
    test_hold();
    run_div(24'h800000, 24'hC00000, 0, 0, 1'b0);       // X < Y, nonterminating
    run_div(24'hFFFFFF, 24'h800000, 10, 20, 1'b0);     // exact, sticky 0
    run_div(24'h800000, 24'hFFFFFF, 1, -1, 1'b0);      // X < Y extreme
    run_div(24'h800000, 24'hC00000, -128, 127, 1'b0);  // exponent -256
    run_div(24'hC00000, 24'h800000, 127, -128, 1'b0);  // exponent 255
    run_div(24'h800001, 24'h800000, 0, 0, 1'b0);       // just above
    run_div(24'h800000, 24'h800001, 0, 0, 1'b0);       // just below
    run_div(24'hB504F3, 24'h9E3779, -7, 4, 1'b0);      // general
    run_div(24'hA00000, 24'hE00000, 3, 3, 1'b1);       // start while busy
    test_hold();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule